// File: doc/BRIEF.md
# Single-Slot Context Shadow

This block keeps one saved copy of three processor working registers: an 8-bit status byte, an 8-bit accumulator byte and a 4-bit bank-select field. The core takes a snapshot of all three when it vectors to an interrupt of either priority, or when it executes a call that carries the fast flag. A return that carries the fast flag hands the saved copy back to the register file for restoring.

The saved copy is a single slot with no instruction-level read or write path. Every capture event overwrites it. A high-priority interrupt taken inside a low-priority handler therefore destroys the values the low-priority entry saved, and a later fast return restores whatever was captured last. Instruction decode, interrupt arbitration and the register file itself lie outside the block. The block only presents restore values and an enable that the register file uses in the same cycle.

Top module: `ctx_shadow`

## Requirements
- R1: When reset is asserted (rst_n low), all three shadow fields become zero. A fast return that comes before any capture restores status 0x00, accumulator 0x00 and bank 0x0.
- R2: An interrupt-vector strobe of either priority (irq_vec_lo or irq_vec_hi high) copies status_in, wreg_in and bsr_in into the shadow at that clock edge.
- R3: A call with the fast flag (call_valid and call_fast both high) copies the three live values into the shadow at that clock edge.
- R4: A call without the fast flag (call_valid high, call_fast low) leaves the shadow unchanged.
- R5: A return with the fast flag (ret_valid and ret_fast high) drives restore_en high in that same cycle, with status_out, wreg_out and bsr_out equal to the shadow contents.
- R6: A return without the fast flag (ret_valid high, ret_fast low) keeps restore_en low and leaves the shadow unchanged.
- R7: Only one slot exists. A high-priority capture that follows a low-priority capture replaces the earlier values, and the next fast return restores the high-priority values.
- R8: When a capture and a fast return fall in the same cycle, the restore outputs carry the shadow contents from before that capture. The shadow then holds the new capture.
- R9: While restore_en is low, status_out, wreg_out and bsr_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| status_in | input | 8 | Live status register value |
| wreg_in | input | 8 | Live accumulator value |
| bsr_in | input | 4 | Live bank-select value |
| irq_vec_lo | input | 1 | Core vectors to a low-priority interrupt |
| irq_vec_hi | input | 1 | Core vectors to a high-priority interrupt |
| call_valid | input | 1 | A call instruction executes |
| call_fast | input | 1 | Fast flag of that call |
| ret_valid | input | 1 | A return instruction executes |
| ret_fast | input | 1 | Fast flag of that return |
| restore_en | output | 1 | Register file loads the restore values |
| status_out | output | 8 | Status restore value |
| wreg_out | output | 8 | Accumulator restore value |
| bsr_out | output | 4 | Bank-select restore value |

## Verification
The restore outputs are combinational. They are due in the same cycle as the return strobe, so the bench sets its inputs on the falling edge and samples 2 ns later, before the next rising edge. A capture takes effect at the rising edge that ends the strobe cycle, so it becomes visible only in the next sampled cycle. The bench's own model of the slot updates at that edge, after the sample has been taken. This ordering also gives the same-cycle capture-and-restore case its expected result: the old values appear on the outputs and the new values appear in the following cycle.

// File: rtl/ctx_shadow_pkg.sv
// Shared widths and the context record for the shadow block.
// Assumes the status and accumulator registers have the same width.
package ctx_shadow_pkg;
    parameter int DATA_W = 8;
    parameter int BANK_W = 4;
    localparam int CTX_W = 2 * DATA_W + BANK_W;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] wreg;
        logic [BANK_W-1:0] bank;
    } ctx_t;
endpackage

// File: rtl/ctx_capture_ctrl.sv
// Decodes the event strobes into capture and restore commands.
// Assumes the strobes are single-cycle and already qualified by the core.
module ctx_capture_ctrl (
    input  logic irq_vec_lo,
    input  logic irq_vec_hi,
    input  logic call_valid,
    input  logic call_fast,
    input  logic ret_valid,
    input  logic ret_fast,
    output logic capture,
    output logic restore
);
    // Either interrupt priority or a fast call loads the one slot.
    always_comb begin
        capture = irq_vec_lo | irq_vec_hi | (call_valid & call_fast);
        restore = ret_valid & ret_fast;
    end
endmodule

// File: rtl/ctx_slot.sv
// One shadow field: a register that loads on capture and clears on reset.
// Assumes reset is synchronous and active low.
module ctx_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the saved value until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/ctx_restore_gate.sv
// Drives the saved record onto the restore bus only while a restore runs.
// Assumes the consumer ignores the bus when the enable is low.
module ctx_restore_gate #(
    parameter int W = 20
) (
    input  logic         en,
    input  logic [W-1:0] saved,
    output logic [W-1:0] bus
);
    // Bit-wise gating, one AND per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bus[i] = en & saved[i];
    end
endmodule

// File: rtl/ctx_shadow.sv
// Single-entry shadow of status, accumulator and bank select.
// Any interrupt or fast call overwrites the slot. A fast return presents the
// slot combinationally in the same cycle. A capture in that cycle lands after it.
module ctx_shadow
    import ctx_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] wreg_in,
    input  logic [BANK_W-1:0] bsr_in,
    input  logic              irq_vec_lo,
    input  logic              irq_vec_hi,
    input  logic              call_valid,
    input  logic              call_fast,
    input  logic              ret_valid,
    input  logic              ret_fast,
    output logic              restore_en,
    output logic [DATA_W-1:0] status_out,
    output logic [DATA_W-1:0] wreg_out,
    output logic [BANK_W-1:0] bsr_out
);
    logic capture;
    logic restore;
    ctx_t live;
    ctx_t saved;
    ctx_t bus;

    // Collect the live inputs into one record.
    always_comb begin
        live.status = status_in;
        live.wreg   = wreg_in;
        live.bank   = bsr_in;
    end

    ctx_capture_ctrl u_ctrl (
        .irq_vec_lo (irq_vec_lo),
        .irq_vec_hi (irq_vec_hi),
        .call_valid (call_valid),
        .call_fast  (call_fast),
        .ret_valid  (ret_valid),
        .ret_fast   (ret_fast),
        .capture    (capture),
        .restore    (restore)
    );

    ctx_slot #(.W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .load(capture), .d(live.status), .q(saved.status)
    );
    ctx_slot #(.W(DATA_W)) u_wreg (
        .clk(clk), .rst_n(rst_n), .load(capture), .d(live.wreg), .q(saved.wreg)
    );
    ctx_slot #(.W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(capture), .d(live.bank), .q(saved.bank)
    );

    ctx_restore_gate #(.W(CTX_W)) u_gate (
        .en(restore), .saved(saved), .bus(bus)
    );

    // Split the restore record onto the output ports.
    always_comb begin
        restore_en = restore;
        status_out = bus.status;
        wreg_out   = bus.wreg;
        bsr_out    = bus.bank;
    end
endmodule

// File: rtl/ctx_shadow_chk.sv
// Temporal checks on the shadow block's ports, attached by bind.
module ctx_shadow_chk
    import ctx_shadow_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] status_in,
    input logic [DATA_W-1:0] wreg_in,
    input logic [BANK_W-1:0] bsr_in,
    input logic              irq_vec_lo,
    input logic              irq_vec_hi,
    input logic              call_valid,
    input logic              call_fast,
    input logic              ret_valid,
    input logic              ret_fast,
    input logic              restore_en,
    input logic [DATA_W-1:0] status_out,
    input logic [DATA_W-1:0] wreg_out,
    input logic [BANK_W-1:0] bsr_out
);
    logic cap_any;
    assign cap_any = irq_vec_lo | irq_vec_hi | (call_valid & call_fast);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_en |-> (status_out == '0 && wreg_out == '0 && bsr_out == '0));

    assert_fast_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_fast) |-> restore_en);

    assert_plain_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_fast) |-> !restore_en);

    assert_irq_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec_lo || irq_vec_hi) |=> (!restore_en ||
            (status_out == $past(status_in) && wreg_out == $past(wreg_in)
             && bsr_out == $past(bsr_in))));

    assert_call_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && call_fast) |=> (!restore_en ||
            (status_out == $past(status_in) && wreg_out == $past(wreg_in)
             && bsr_out == $past(bsr_in))));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_en && $past(restore_en) && !$past(cap_any)) |->
            ($stable(status_out) && $stable(wreg_out) && $stable(bsr_out)));
endmodule

bind ctx_shadow ctx_shadow_chk u_chk (.*);

// File: tb/test_ctx_shadow.sv
module test_ctx_shadow;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] status_in = '0, wreg_in = '0;
    logic [3:0] bsr_in = '0;
    logic       irq_vec_lo = 0, irq_vec_hi = 0, call_valid = 0, call_fast = 0;
    logic       ret_valid = 0, ret_fast = 0;
    logic       restore_en;
    logic [7:0] status_out, wreg_out;
    logic [3:0] bsr_out;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] m_st = '0, m_wr = '0;
    logic [3:0] m_bk = '0;

    always #4 clk = ~clk;

    ctx_shadow i_ctx_shadow (.*);

    task automatic check(string req, logic [20:0] act, logic [20:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample 2 ns later, then advance the model at the rising edge.
    task automatic step(string req, logic [7:0] st, logic [7:0] wr, logic [3:0] bk,
                        logic lo, logic hi, logic cv, logic cf, logic rv, logic rf);
        logic en;
        @(negedge clk);
        status_in = st; wreg_in = wr; bsr_in = bk;
        irq_vec_lo = lo; irq_vec_hi = hi; call_valid = cv; call_fast = cf;
        ret_valid = rv; ret_fast = rf;
        #2;
        en = rv & rf;
        check(req, {restore_en, status_out, wreg_out, bsr_out},
              en ? {1'b1, m_st, m_wr, m_bk} : 21'd0);
        @(posedge clk);
        if (lo | hi | (cv & cf)) begin
            m_st = st; m_wr = wr; m_bk = bk;
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: with a capture request held during reset, the slot must stay zero.
        @(negedge clk);
        irq_vec_hi = 1; status_in = 8'hAA; wreg_in = 8'h55; bsr_in = 4'hF;
        @(posedge clk);
        @(negedge clk);
        irq_vec_hi = 0; rst_n = 1;
        step("R1", 8'h11, 8'h22, 4'h3, 0, 0, 0, 0, 1, 1);
        // R2: each interrupt priority captures.
        step("R2", 8'h3C, 8'hC3, 4'h9, 1, 0, 0, 0, 0, 0);
        step("R2", 8'h00, 8'h00, 4'h0, 0, 0, 0, 0, 1, 1);
        step("R2", 8'h7E, 8'h81, 4'h6, 0, 1, 0, 0, 0, 0);
        step("R2", 8'h00, 8'h00, 4'h0, 0, 0, 0, 0, 1, 1);
        // R3 and R4: a fast call captures, a plain call does not.
        step("R3", 8'hD4, 8'h4D, 4'h2, 0, 0, 1, 1, 0, 0);
        step("R4", 8'hFF, 8'hFF, 4'hF, 0, 0, 1, 0, 0, 0);
        step("R4", 8'h00, 8'h00, 4'h0, 0, 0, 0, 0, 1, 1);
        // R6: a plain return is quiet and leaves the slot as it was.
        step("R6", 8'h12, 8'h34, 4'h5, 0, 0, 0, 0, 1, 0);
        step("R6", 8'h00, 8'h00, 4'h0, 0, 0, 0, 0, 1, 1);
        // R7: a high-priority capture inside a low-priority handler wins.
        step("R7", 8'h01, 8'h02, 4'h3, 1, 0, 0, 0, 0, 0);
        step("R7", 8'h00, 8'h00, 4'h0, 0, 0, 0, 0, 0, 0);
        step("R7", 8'hF1, 8'hF2, 4'hC, 0, 1, 0, 0, 0, 0);
        step("R7", 8'h00, 8'h00, 4'h0, 0, 0, 0, 0, 1, 1);
        // R8: a capture and a fast return in the same cycle; the old values come out first.
        step("R8", 8'h9A, 8'hA9, 4'h7, 1, 0, 0, 0, 1, 1);
        step("R8", 8'h00, 8'h00, 4'h0, 0, 0, 0, 0, 1, 1);
        // Sweep of all 64 strobe combinations over four data patterns.
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 64; c++) begin
                logic [7:0] st, wr;
                logic [3:0] bk;
                logic [5:0] s;
                string tag;
                s  = 6'(c);
                st = 8'(c * 37 + p * 91 + 5);
                wr = 8'(c * 113 + p * 29 + 17);
                bk = 4'(c * 7 + p * 3);
                if (s[1] & s[0] & (s[5] | s[4] | (s[3] & s[2]))) tag = "R8";
                else if (s[1] & s[0]) tag = "R5";
                else if (s[1]) tag = "R6";
                else tag = "R9";
                step(tag, st, wr, bk, s[5], s[4], s[3], s[2], s[1], s[0]);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule